// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block sits between store execution and the data cache. An executed store writes its word address and data into a circular queue together with its instruction tag, and the entry is marked speculative. Nothing reaches the cache while a store is speculative. A commit carrying the store's tag clears that mark. The drain port then hands committed entries to the cache one at a time, oldest first. A kill carrying a tag boundary discards every entry younger than the boundary in one cycle by pulling the tail back. Killed stores are never written.

Loads look up the queue in parallel with the cache. Only entries older than the load's own tag take part. If several of them hold the load's word address, the youngest of them supplies the value. A store-buffer hit overrides whatever the cache returns. Tags are sequence numbers that wrap. Age is decided by modular difference, so the tags in flight must span less than half the tag space.

Queue occupancy is tracked by a three-state controller. Q_EMPTY goes to Q_OPEN on the first accepted allocation. Q_OPEN goes to Q_FULL when the count reaches the depth, and to Q_EMPTY when a drain or kill removes the last entry. Q_FULL goes back to Q_OPEN, or straight to Q_EMPTY, when a drain or a kill frees entries.

Top module: `spec_store_buffer`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `drain_valid` is 0 and no load lookup reports `ld_fwd`.
- R2: An allocation is accepted when `alloc_valid` and `alloc_ready` are both 1. After DEPTH (8) entries are held, `alloc_ready` is 0, and an allocation offered while full is dropped and leaves no trace in lookups.
- R3: A speculative entry at the head of the queue is never offered on the drain port (`drain_valid` stays 0). This holds even when younger entries have already committed.
- R4: A commit whose tag equals a held entry's tag clears that entry's speculative mark. When that entry is the head, `drain_valid` rises on the next cycle and shows its address and data.
- R5: Entries drain oldest first. The head stays on `drain_addr`/`drain_data` unchanged while `drain_ready` is 0. It is freed in the cycle where `drain_valid` and `drain_ready` are both 1.
- R6: A load with address A and tag L gets `ld_fwd`=1, `ld_hit`=1 and the stored data when a held entry with address A has a tag older than L.
- R7: When several older entries match the load address, the data comes from the youngest of them.
- R8: Entries whose tag equals or is younger than the load's tag are ignored by the lookup.
- R9: Without a store-buffer match, `ld_hit` equals `cache_hit` and `ld_data` equals `cache_data`. With a match, the buffered data is returned regardless of the cache.
- R10: A kill with tag K removes, in the cycle it is presented, every held entry younger than K. Older entries, and an entry with tag K itself, survive. Removed entries never forward and never drain.
- R11: While `kill_valid` is 1, `alloc_ready` is 0 and any offered allocation is dropped.
- R12: Tag a is older than tag b when (b − a) mod 2^TAGW is nonzero and has its top bit clear. For example, with 8-bit tags, 250 is older than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Executed store offered for insertion |
| alloc_ready | output | 1 | Queue can accept a store this cycle |
| alloc_tag | input | TAGW | Instruction tag of the offered store |
| alloc_addr | input | AW | Word address of the offered store |
| alloc_data | input | DW | Data of the offered store |
| commit_valid | input | 1 | A store is committing |
| commit_tag | input | TAGW | Tag of the committing store |
| kill_valid | input | 1 | Discard stores younger than the boundary |
| kill_tag | input | TAGW | Kill boundary tag |
| ld_addr | input | AW | Load word address |
| ld_tag | input | TAGW | Load instruction tag |
| cache_hit | input | 1 | Data cache hit for the load |
| cache_data | input | DW | Data cache read value |
| ld_hit | output | 1 | Load value available |
| ld_fwd | output | 1 | Load value comes from the store buffer |
| ld_data | output | DW | Load value |
| drain_valid | output | 1 | Committed head entry offered to cache |
| drain_ready | input | 1 | Cache accepts the offered entry |
| drain_addr | output | AW | Word address of the offered entry |
| drain_data | output | DW | Data of the offered entry |

## Verification
A head or tail pointer that is off by one shows up at once. The next lookup forwards a stale or missing value, or the drain port offers the wrong address, in the cycle after the faulty update. A speculative bit that is cleared too early or too late shows as `drain_valid` rising one cycle off from the commit. A wrong kill count shows as a killed store still forwarding on the next lookup, or as a survivor drained out of order several cycles later. Faults in the age comparison appear only near tag wrap, so the bench runs tags across the wrap point.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_OPEN  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;
endpackage

// File: rtl/ssb_age_cmp.sv
// Modular age test: older_o is 1 when tag_a was issued before tag_b.
module ssb_age_cmp #(
    parameter int TAGW = 8
) (
    input  logic [TAGW-1:0] tag_a,
    input  logic [TAGW-1:0] tag_b,
    output logic            older_o
);
    logic [TAGW-1:0] diff;
    assign diff    = tag_b - tag_a;
    assign older_o = (diff != '0) && !diff[TAGW-1];
endmodule

// File: rtl/ssb_entry_array.sv
module ssb_entry_array #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TAGW  = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDXW-1:0]            wr_idx,
    input  logic [TAGW-1:0]            wr_tag,
    input  logic [AW-1:0]              wr_addr,
    input  logic [DW-1:0]              wr_data,
    input  logic                       commit_valid,
    input  logic [TAGW-1:0]            commit_tag,
    input  logic                       pop_en,
    input  logic [IDXW-1:0]            pop_idx,
    input  logic [DEPTH-1:0]           kill_mask,
    output logic [DEPTH-1:0]           ent_vld,
    output logic [DEPTH-1:0]           ent_spec,
    output logic [DEPTH-1:0][TAGW-1:0] ent_tag,
    output logic [DEPTH-1:0][AW-1:0]   ent_addr,
    output logic [DEPTH-1:0][DW-1:0]   ent_data
);
    for (genvar j = 0; j < DEPTH; j++) begin : g_ent
        logic sel_wr, sel_pop, sel_cmt;
        assign sel_wr  = wr_en  && (wr_idx  == IDXW'(j));
        assign sel_pop = pop_en && (pop_idx == IDXW'(j));
        assign sel_cmt = commit_valid && ent_vld[j] && (ent_tag[j] == commit_tag);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[j]  <= 1'b0;
                ent_spec[j] <= 1'b0;
            end else if (sel_wr) begin
                ent_vld[j]  <= 1'b1;
                ent_spec[j] <= 1'b1;
            end else begin
                if (sel_pop || kill_mask[j]) ent_vld[j] <= 1'b0;
                if (sel_cmt)                 ent_spec[j] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (sel_wr) begin
                ent_tag[j]  <= wr_tag;
                ent_addr[j] <= wr_addr;
                ent_data[j] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/ssb_queue_ctrl.sv
module ssb_queue_ctrl
    import ssb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAGW  = 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CW   = IDXW + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_valid,
    input  logic                       kill_valid,
    input  logic [TAGW-1:0]            kill_tag,
    input  logic                       drain_ready,
    input  logic [DEPTH-1:0]           ent_vld,
    input  logic [DEPTH-1:0]           ent_spec,
    input  logic [DEPTH-1:0][TAGW-1:0] ent_tag,
    output logic                       alloc_ready,
    output logic                       alloc_fire,
    output logic                       drain_valid,
    output logic                       drain_fire,
    output logic [IDXW-1:0]            head_q,
    output logic [IDXW-1:0]            tail_q,
    output logic [CW-1:0]              cnt_q,
    output logic [DEPTH-1:0]           kill_mask
);
    q_state_e        state_q, state_d;
    logic [CW-1:0]   cnt_d, nkill;
    logic [IDXW-1:0] head_d, tail_d;

    // Kill window: held entries strictly younger than the boundary.
    for (genvar j = 0; j < DEPTH; j++) begin : g_kill
        logic [IDXW-1:0] off;
        logic            younger;
        assign off = IDXW'(j) - head_q;
        ssb_age_cmp #(.TAGW(TAGW)) age_i (
            .tag_a   (kill_tag),
            .tag_b   (ent_tag[j]),
            .older_o (younger)
        );
        assign kill_mask[j] = kill_valid && ({1'b0, off} < cnt_q) && younger;
    end

    always_comb begin
        nkill = '0;
        for (int j = 0; j < DEPTH; j++) nkill = nkill + CW'(kill_mask[j]);
    end

    // Output process: handshake signals from the current state.
    always_comb begin
        alloc_ready = 1'b0;
        drain_valid = 1'b0;
        unique case (state_q)
            Q_EMPTY: alloc_ready = !kill_valid;
            Q_OPEN: begin
                alloc_ready = !kill_valid;
                drain_valid = ent_vld[head_q] && !ent_spec[head_q];
            end
            Q_FULL:  drain_valid = ent_vld[head_q] && !ent_spec[head_q];
            default: ;
        endcase
    end

    assign alloc_fire = alloc_valid && alloc_ready;
    assign drain_fire = drain_valid && drain_ready;

    always_comb begin
        head_d = head_q + IDXW'(drain_fire);
        if (kill_valid) begin
            tail_d = tail_q - nkill[IDXW-1:0];
            cnt_d  = cnt_q - nkill - CW'(drain_fire);
        end else begin
            tail_d = tail_q + IDXW'(alloc_fire);
            cnt_d  = cnt_q + CW'(alloc_fire) - CW'(drain_fire);
        end
    end

    // Next-state process: named transitions between occupancy states.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: if (cnt_d != '0) state_d = Q_OPEN;
            Q_OPEN: begin
                if (cnt_d == '0)            state_d = Q_EMPTY;
                else if (cnt_d == CW'(DEPTH)) state_d = Q_FULL;
            end
            Q_FULL: begin
                if (cnt_d == '0)            state_d = Q_EMPTY;
                else if (cnt_d != CW'(DEPTH)) state_d = Q_OPEN;
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            head_q  <= '0;
            tail_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            head_q  <= head_d;
            tail_q  <= tail_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/ssb_load_fwd.sv
module ssb_load_fwd #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TAGW  = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]           ent_vld,
    input  logic [DEPTH-1:0][TAGW-1:0] ent_tag,
    input  logic [DEPTH-1:0][AW-1:0]   ent_addr,
    input  logic [DEPTH-1:0][DW-1:0]   ent_data,
    input  logic [IDXW-1:0]            head,
    input  logic [AW-1:0]              ld_addr,
    input  logic [TAGW-1:0]            ld_tag,
    output logic                       fwd_hit,
    output logic [DW-1:0]              fwd_data
);
    logic [DEPTH-1:0] match;

    for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
        logic older;
        ssb_age_cmp #(.TAGW(TAGW)) age_i (
            .tag_a   (ent_tag[j]),
            .tag_b   (ld_tag),
            .older_o (older)
        );
        assign match[j] = ent_vld[j] && older && (ent_addr[j] == ld_addr);
    end

    // Walk from oldest to youngest; the last match seen is the youngest.
    always_comb begin
        fwd_hit  = 1'b0;
        fwd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[IDXW'(head + IDXW'(i))]) begin
                fwd_hit  = 1'b1;
                fwd_data = ent_data[IDXW'(head + IDXW'(i))];
            end
        end
    end
endmodule

// File: rtl/spec_store_buffer.sv
module spec_store_buffer #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TAGW  = 8,
    localparam int IDXW = $clog2(DEPTH),
    localparam int CW   = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    output logic            alloc_ready,
    input  logic [TAGW-1:0] alloc_tag,
    input  logic [AW-1:0]   alloc_addr,
    input  logic [DW-1:0]   alloc_data,
    input  logic            commit_valid,
    input  logic [TAGW-1:0] commit_tag,
    input  logic            kill_valid,
    input  logic [TAGW-1:0] kill_tag,
    input  logic [AW-1:0]   ld_addr,
    input  logic [TAGW-1:0] ld_tag,
    input  logic            cache_hit,
    input  logic [DW-1:0]   cache_data,
    output logic            ld_hit,
    output logic            ld_fwd,
    output logic [DW-1:0]   ld_data,
    output logic            drain_valid,
    input  logic            drain_ready,
    output logic [AW-1:0]   drain_addr,
    output logic [DW-1:0]   drain_data
);
    logic                       alloc_fire, drain_fire;
    logic [IDXW-1:0]            head_q, tail_q;
    logic [CW-1:0]              cnt_q;
    logic [DEPTH-1:0]           kill_mask, ent_vld, ent_spec;
    logic [DEPTH-1:0][TAGW-1:0] ent_tag;
    logic [DEPTH-1:0][AW-1:0]   ent_addr;
    logic [DEPTH-1:0][DW-1:0]   ent_data;
    logic                       fwd_hit;
    logic [DW-1:0]              fwd_data;

    ssb_queue_ctrl #(.DEPTH(DEPTH), .TAGW(TAGW)) ctrl_i (
        .clk, .rst_n, .alloc_valid, .kill_valid, .kill_tag, .drain_ready,
        .ent_vld, .ent_spec, .ent_tag,
        .alloc_ready, .alloc_fire, .drain_valid, .drain_fire,
        .head_q, .tail_q, .cnt_q, .kill_mask
    );

    ssb_entry_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW)) ent_i (
        .clk, .rst_n,
        .wr_en(alloc_fire), .wr_idx(tail_q), .wr_tag(alloc_tag),
        .wr_addr(alloc_addr), .wr_data(alloc_data),
        .commit_valid, .commit_tag,
        .pop_en(drain_fire), .pop_idx(head_q), .kill_mask,
        .ent_vld, .ent_spec, .ent_tag, .ent_addr, .ent_data
    );

    ssb_load_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW)) fwd_i (
        .ent_vld, .ent_tag, .ent_addr, .ent_data, .head(head_q),
        .ld_addr, .ld_tag, .fwd_hit, .fwd_data
    );

    assign ld_fwd     = fwd_hit;
    assign ld_hit     = fwd_hit || cache_hit;
    assign ld_data    = fwd_hit ? fwd_data : cache_data;
    assign drain_addr = ent_addr[head_q];
    assign drain_data = ent_data[head_q];
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          alloc_ready,
    input logic          kill_valid,
    input logic          drain_valid,
    input logic          drain_ready,
    input logic [AW-1:0] drain_addr,
    input logic [DW-1:0] drain_data,
    input logic          ld_fwd,
    input logic [CW-1:0] cnt
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R2
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH)) |-> !alloc_ready); // R2
    AST_EMPTY_NO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !drain_valid); // R3
    AST_EMPTY_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !ld_fwd); // R6
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && !drain_ready) |=>
            (drain_valid && $stable(drain_addr) && $stable(drain_data))); // R5
    AST_POP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && drain_ready && !kill_valid && !(alloc_valid && alloc_ready))
            |=> (cnt == $past(cnt) - CW'(1))); // R5
    AST_KILL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        kill_valid |-> !alloc_ready); // R11
endmodule

bind spec_store_buffer ssb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .kill_valid(kill_valid), .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_addr(drain_addr), .drain_data(drain_data), .ld_fwd(ld_fwd), .cnt(cnt_q)
);

// File: tb/spec_store_buffer_tb_top.sv
module spec_store_buffer_tb_top;
    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int TAGW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0, commit_valid = 0, kill_valid = 0, cache_hit = 0, drain_ready = 0;
    logic [TAGW-1:0] alloc_tag = '0, commit_tag = '0, kill_tag = '0, ld_tag = '0;
    logic [AW-1:0] alloc_addr = '0, ld_addr = '0;
    logic [DW-1:0] alloc_data = '0, cache_data = '0;
    logic alloc_ready, ld_hit, ld_fwd, drain_valid;
    logic [DW-1:0] ld_data, drain_data;
    logic [AW-1:0] drain_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    spec_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW)) dut_i (.*);

    typedef struct packed {
        logic [AW-1:0]   addr;
        logic [TAGW-1:0] tag;
        logic            chit;
        logic [DW-1:0]   cdata;
        logic            ehit;
        logic            efwd;
        logic [DW-1:0]   edata;
        logic [7:0]      req;
    } vec_t;

    // Held stores: tag10@0x100=A0, tag12@0x104=A1, tag14@0x100=A2, tag16@0x108=A3
    localparam vec_t VEC [10] = '{
        '{32'h100, 8'd11,  1'b0, 32'h0,  1'b1, 1'b1, 32'hA0, 8'd6},  // R6
        '{32'h100, 8'd15,  1'b0, 32'h0,  1'b1, 1'b1, 32'hA2, 8'd7},  // R7
        '{32'h100, 8'd14,  1'b0, 32'h0,  1'b1, 1'b1, 32'hA0, 8'd8},  // R8 same tag ignored
        '{32'h100, 8'd10,  1'b1, 32'hCC, 1'b1, 1'b0, 32'hCC, 8'd9},  // R9 cache passes
        '{32'h10C, 8'd20,  1'b0, 32'h0,  1'b0, 1'b0, 32'h0,  8'd9},  // R9 miss
        '{32'h104, 8'd20,  1'b1, 32'hDD, 1'b1, 1'b1, 32'hA1, 8'd9},  // R9 buffer wins
        '{32'h108, 8'd16,  1'b0, 32'h0,  1'b0, 1'b0, 32'h0,  8'd8},  // R8
        '{32'h108, 8'd17,  1'b0, 32'h0,  1'b1, 1'b1, 32'hA3, 8'd6},  // R6
        '{32'h100, 8'd100, 1'b0, 32'h0,  1'b1, 1'b1, 32'hA2, 8'd7},  // R7
        '{32'h100, 8'd200, 1'b0, 32'h0,  1'b0, 1'b0, 32'h0,  8'd12}  // R12 far tag is not younger
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic alloc(input logic [TAGW-1:0] t, input logic [AW-1:0] a, input logic [DW-1:0] d);
        alloc_valid = 1; alloc_tag = t; alloc_addr = a; alloc_data = d;
        step();
        alloc_valid = 0;
    endtask

    task automatic commit(input logic [TAGW-1:0] t);
        commit_valid = 1; commit_tag = t;
        step();
        commit_valid = 0;
    endtask

    task automatic pop();
        drain_ready = 1;
        step();
        drain_ready = 0;
    endtask

    task automatic lookup(input string req, input logic [AW-1:0] a, input logic [TAGW-1:0] t,
                          input logic ch, input logic [DW-1:0] cd,
                          input logic eh, input logic ef, input logic [DW-1:0] ed);
        ld_addr = a; ld_tag = t; cache_hit = ch; cache_data = cd;
        #2;
        chk({req, " ld_hit"}, 64'(ld_hit), 64'(eh));
        chk({req, " ld_fwd"}, 64'(ld_fwd), 64'(ef));
        if (eh) chk({req, " ld_data"}, 64'(ld_data), 64'(ed));
        cache_hit = 0;
    endtask

    task automatic drain_is(input string req, input logic ev, input logic [AW-1:0] a, input logic [DW-1:0] d);
        chk({req, " drain_valid"}, 64'(drain_valid), 64'(ev));
        if (ev) begin
            chk({req, " drain_addr"}, 64'(drain_addr), 64'(a));
            chk({req, " drain_data"}, 64'(drain_data), 64'(d));
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #2;
        // R1 reset state
        chk("R1 alloc_ready", 64'(alloc_ready), 64'd1);
        chk("R1 drain_valid", 64'(drain_valid), 64'd0);
        lookup("R1", 32'h0, 8'd5, 1'b0, '0, 1'b0, 1'b0, '0);

        alloc(8'd10, 32'h100, 32'hA0);
        alloc(8'd12, 32'h104, 32'hA1);
        alloc(8'd14, 32'h100, 32'hA2);
        alloc(8'd16, 32'h108, 32'hA3);

        for (int i = 0; i < 10; i++) begin
            ld_addr = VEC[i].addr; ld_tag = VEC[i].tag;
            cache_hit = VEC[i].chit; cache_data = VEC[i].cdata;
            #2;
            chk($sformatf("R%0d vec%0d ld_hit", VEC[i].req, i), 64'(ld_hit), 64'(VEC[i].ehit));
            chk($sformatf("R%0d vec%0d ld_fwd", VEC[i].req, i), 64'(ld_fwd), 64'(VEC[i].efwd));
            if (VEC[i].ehit)
                chk($sformatf("R%0d vec%0d ld_data", VEC[i].req, i), 64'(ld_data), 64'(VEC[i].edata));
        end
        cache_hit = 0;

        drain_is("R3 all speculative", 1'b0, '0, '0);
        commit(8'd12);
        drain_is("R3 head still speculative", 1'b0, '0, '0);
        commit(8'd10);
        drain_is("R4 head committed", 1'b1, 32'h100, 32'hA0);
        step(); step();
        drain_is("R5 held without ready", 1'b1, 32'h100, 32'hA0);
        pop();
        drain_is("R5 next oldest", 1'b1, 32'h104, 32'hA1);
        pop();
        drain_is("R3 speculative head after drain", 1'b0, '0, '0);
        lookup("R5 drained entry freed", 32'h104, 8'd20, 1'b0, '0, 1'b0, 1'b0, '0);

        // Kill younger than 14 with a simultaneous allocation attempt.
        kill_valid = 1; kill_tag = 8'd14;
        alloc_valid = 1; alloc_tag = 8'd50; alloc_addr = 32'h200; alloc_data = 32'hEE;
        #2;
        chk("R11 alloc_ready during kill", 64'(alloc_ready), 64'd0);
        step();
        kill_valid = 0; alloc_valid = 0;
        lookup("R10 killed entry gone", 32'h108, 8'd30, 1'b0, '0, 1'b0, 1'b0, '0);
        lookup("R10 boundary survives", 32'h100, 8'd30, 1'b0, '0, 1'b1, 1'b1, 32'hA2);
        lookup("R11 dropped allocation", 32'h200, 8'd60, 1'b0, '0, 1'b0, 1'b0, '0);
        commit(8'd14);
        drain_is("R10 survivor drains", 1'b1, 32'h100, 32'hA2);
        pop();
        drain_is("R10 killed never drains", 1'b0, '0, '0);
        chk("R1 ready when empty again", 64'(alloc_ready), 64'd1);

        // Fill across tag wrap: 250,252,254,0,2,4,6,8
        for (int i = 0; i < DEPTH; i++)
            alloc(TAGW'(250 + 2 * i), AW'(32'h300 + 4 * i), DW'(32'h50 + i));
        chk("R2 full blocks", 64'(alloc_ready), 64'd0);
        alloc(8'd10, 32'h400, 32'h99);
        lookup("R2 allocation while full dropped", 32'h400, 8'd20, 1'b0, '0, 1'b0, 1'b0, '0);
        lookup("R12 wrapped older", 32'h300, 8'd3, 1'b0, '0, 1'b1, 1'b1, 32'h50);
        lookup("R6 post-wrap store", 32'h30C, 8'd20, 1'b0, '0, 1'b1, 1'b1, 32'h53);

        kill_valid = 1; kill_tag = 8'd254;
        step();
        kill_valid = 0;
        lookup("R12 wrapped younger killed", 32'h30C, 8'd20, 1'b0, '0, 1'b0, 1'b0, '0);
        lookup("R10 kill boundary kept", 32'h308, 8'd20, 1'b0, '0, 1'b1, 1'b1, 32'h52);
        chk("R10 space freed", 64'(alloc_ready), 64'd1);

        commit(8'd250); commit(8'd252); commit(8'd254);
        drain_is("R5 order 1", 1'b1, 32'h300, 32'h50);
        pop();
        drain_is("R5 order 2", 1'b1, 32'h304, 32'h51);
        pop();
        drain_is("R5 order 3", 1'b1, 32'h308, 32'h52);
        pop();
        drain_is("R10 nothing left", 1'b0, '0, '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule